// File: doc/BRIEF.md
# Fraction Accumulator and Multiplier-Quotient Unit

This block is the arithmetic core of a single-accumulator processor. It owns two architected registers: the accumulator (`acc`) and the multiplier-quotient register (`mq`). Both hold 40-bit two's-complement fractions in the range -1 <= f < +1. A controller presents a 4-bit operation code and the memory operand fetched for the instruction, and raises `start` for one cycle. The unit then updates `acc` and/or `mq` and pulses `done`.

Adds, subtracts, register moves and shifts finish on the same clock edge that accepts `start`. Multiply and divide run as bit-serial shift-and-add and shift-and-subtract sequencers, and `busy` stays high while they run. Divide by zero and quotient overflow give a saturated quotient and set a sticky error flag. The `accNonNeg` output gives the controller the test it needs for a conditional branch.

Top module: `acmq_unit`

## Requirements
- R1: After reset `acc` and `mq` are zero, `busy`, `done` and `divErr` are low and `accNonNeg` is high. Reset also clears a set `divErr`.
- R2: Codes 0 to 3 replace `acc` with +M, -M, +|M| and -|M| in that order. Bit 0 of the code selects negation and bit 1 selects the magnitude.
- R3: Codes 4 to 7 add +M, -M, +|M| or -|M| to the old `acc`, using the same bit meanings as R2. All sums and negations wrap modulo 2^40, so |-1| stays -1.
- R4: Code 8 loads `mq` with M. Code 9 copies `mq` into `acc`.
- R5: Code 10 forms the 80-bit signed product p = M x `mq`. It writes `acc` = p[78:39] and `mq` = {0, p[38:0]}.
- R6: Code 11 divides `acc`·2^39 by M, truncating toward zero. The quotient goes to `mq`. The remainder goes to `acc` and carries the dividend's sign. An exact quotient of -1 is a valid result.
- R7: When M is zero or the quotient falls outside the fraction range, code 11 leaves `acc` unchanged and loads `mq` with the most negative value if the operand signs differ, otherwise with the most positive value. It also sets `divErr`, which stays set until reset.
- R8: Code 12 shifts `acc` left by one and drops the bit shifted out. Code 13 shifts `acc` right arithmetically. Codes 14 and 15 change neither register.
- R9: For every code except a sequenced multiply or divide, `done` is high in the cycle right after the edge that accepts `start`. A multiply keeps `busy` high for 40 cycles, and `done` follows in cycle 41. A sequenced divide keeps `busy` high for 39 cycles, and `done` follows in cycle 40. Divides that fault or give exactly -1 finish in one cycle.
- R10: A `start` that arrives while `busy` is high is ignored. `acc` and `mq` stay stable while `busy` is high.
- R11: `accNonNeg` is the inverse of the sign bit of `acc`.
- R12: `done` is a single-cycle pulse and is never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted when not busy |
| opCode | input | 4 | Operation code (see R2 to R8) |
| operand | input | 40 | Memory operand M |
| busy | output | 1 | Multiply or divide sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| acc | output | 40 | Accumulator |
| mq | output | 40 | Multiplier-quotient register |
| accNonNeg | output | 1 | High when the accumulator is zero or positive |
| divErr | output | 1 | Sticky divide-fault flag |

## Verification
Every command is applied on a falling edge and accepted on the next rising edge. From there, the bench counts falling edges until `done` is seen. It expects a count of 1 for single-cycle codes, 41 for a multiply and 40 for a sequenced divide. It samples `acc`, `mq` and `divErr` only in that `done` cycle and checks on the following falling edge that `done` has dropped again. A `start` injected part-way through a multiply shows that the multiply latency and result are unaffected and that no extra completion follows.

// File: rtl/acmq_pkg.sv
package acmq_pkg;

  typedef enum logic [3:0] {
    OP_LD_POS   = 4'd0,
    OP_LD_NEG   = 4'd1,
    OP_LD_ABS   = 4'd2,
    OP_LD_NABS  = 4'd3,
    OP_ADD      = 4'd4,
    OP_SUB      = 4'd5,
    OP_ADD_ABS  = 4'd6,
    OP_SUB_ABS  = 4'd7,
    OP_LD_MQ    = 4'd8,
    OP_MQ_TO_AC = 4'd9,
    OP_MUL      = 4'd10,
    OP_DIV      = 4'd11,
    OP_DBL      = 4'd12,
    OP_HALF     = 4'd13,
    OP_NOP_A    = 4'd14,
    OP_NOP_B    = 4'd15
  } op_e;

  typedef enum logic [2:0] {
    ACC_HOLD, ACC_ALU, ACC_FROM_MQ, ACC_DBL, ACC_HALF, ACC_MUL, ACC_DIV, ACC_ZERO
  } accSel_e;

  typedef enum logic [2:0] {
    MQ_HOLD, MQ_OPND, MQ_MUL, MQ_DIV, MQ_SAT, MQ_NEGONE
  } mqSel_e;

  typedef struct packed {
    accSel_e accSel;
    mqSel_e  mqSel;
    logic    aluClear;
    logic    aluNeg;
    logic    aluAbs;
    logic    seqLoadMul;
    logic    seqLoadDiv;
    logic    seqStepMul;
    logic    seqStepDiv;
    logic    setErr;
  } strobe_t;

endpackage

// File: rtl/acmq_ctrl.sv
module acmq_ctrl
  import acmq_pkg::*;
#(
  parameter int W = 40
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic [3:0] opCode,
  input  logic    divFault,
  input  logic    divExactNeg,
  output strobe_t strb,
  output logic    busy,
  output logic    done
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] MUL_LAST = CW'(W - 1);
  localparam logic [CW-1:0] DIV_LAST = CW'(W - 2);

  typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_DIV} st_e;

  st_e state, stateNx;
  logic [CW-1:0] cnt, cntNx;
  logic doneNx;
  op_e op;

  assign op = op_e'(opCode);

  always_comb begin
    strb    = '0;
    stateNx = state;
    cntNx   = cnt;
    doneNx  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          doneNx = 1'b1;
          case (op)
            OP_LD_POS, OP_LD_NEG, OP_LD_ABS, OP_LD_NABS,
            OP_ADD, OP_SUB, OP_ADD_ABS, OP_SUB_ABS: begin
              strb.accSel   = ACC_ALU;
              strb.aluClear = ~opCode[2];
              strb.aluNeg   = opCode[0];
              strb.aluAbs   = opCode[1];
            end
            OP_LD_MQ:    strb.mqSel  = MQ_OPND;
            OP_MQ_TO_AC: strb.accSel = ACC_FROM_MQ;
            OP_MUL: begin
              strb.seqLoadMul = 1'b1;
              stateNx = ST_MUL;
              cntNx   = MUL_LAST;
              doneNx  = 1'b0;
            end
            OP_DIV: begin
              if (divFault) begin
                strb.mqSel  = MQ_SAT;
                strb.setErr = 1'b1;
              end else if (divExactNeg) begin
                strb.accSel = ACC_ZERO;
                strb.mqSel  = MQ_NEGONE;
              end else begin
                strb.seqLoadDiv = 1'b1;
                stateNx = ST_DIV;
                cntNx   = DIV_LAST;
                doneNx  = 1'b0;
              end
            end
            OP_DBL:  strb.accSel = ACC_DBL;
            OP_HALF: strb.accSel = ACC_HALF;
            default: ;
          endcase
        end
      end
      ST_MUL: begin
        strb.seqStepMul = 1'b1;
        if (cnt == '0) begin
          strb.accSel = ACC_MUL;
          strb.mqSel  = MQ_MUL;
          stateNx = ST_IDLE;
          doneNx  = 1'b1;
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      ST_DIV: begin
        strb.seqStepDiv = 1'b1;
        if (cnt == '0) begin
          strb.accSel = ACC_DIV;
          strb.mqSel  = MQ_DIV;
          stateNx = ST_IDLE;
          doneNx  = 1'b1;
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      state <= stateNx;
      cnt   <= cntNx;
      done  <= doneNx;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/acmq_dp.sv
module acmq_dp
  import acmq_pkg::*;
#(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      strb,
  input  logic [W-1:0] operand,
  output logic [W-1:0] acc,
  output logic [W-1:0] mq,
  output logic         divErr,
  output logic         divFault,
  output logic         divExactNeg
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  // magnitudes (most negative maps to 2^(W-1) as an unsigned value)
  logic [W-1:0] accMag, opMag, mqMag;
  assign accMag = acc[W-1]     ? -acc     : acc;
  assign opMag  = operand[W-1] ? -operand : operand;
  assign mqMag  = mq[W-1]      ? -mq      : mq;

  // single-cycle adder path
  logic [W-1:0] opSel, term, aluSum;
  assign opSel  = strb.aluAbs ? opMag : operand;
  assign term   = strb.aluNeg ? -opSel : opSel;
  assign aluSum = (strb.aluClear ? '0 : acc) + term;

  // divide pre-checks
  logic signDiff, magEq;
  assign signDiff    = acc[W-1] ^ operand[W-1];
  assign magEq       = (accMag == opMag);
  assign divFault    = (opMag == '0) | (accMag > opMag) | (magEq & ~signDiff);
  assign divExactNeg = magEq & signDiff;

  // sequencer state
  logic [W-1:0] seqA, seqB, seqM;
  logic negP, negR;

  // multiply step: conditional add then shift right of {seqA, seqB}
  logic [W-1:0] addend, mulHiNx, mulLoNx;
  logic [W:0]   sumHi;
  assign addend  = seqB[0] ? seqM : '0;
  assign sumHi   = {1'b0, seqA} + {1'b0, addend};
  assign mulHiNx = sumHi[W:1];
  assign mulLoNx = {sumHi[0], seqB[W-1:1]};

  logic [2*W-2:0] prodLow, prodSgn;
  assign prodLow = {mulHiNx[W-2:0], mulLoNx};
  assign prodSgn = negP ? -prodLow : prodLow;

  // divide step: restoring shift-and-subtract
  logic [W:0]   remSh;
  logic         geD;
  logic [W-1:0] diffD, remNx, quoNx, quoSgn, remSgn;
  assign remSh  = {seqA, 1'b0};
  assign geD    = remSh >= {1'b0, seqM};
  assign diffD  = remSh[W-1:0] - seqM;
  assign remNx  = geD ? diffD : remSh[W-1:0];
  assign quoNx  = {seqB[W-2:0], geD};
  assign quoSgn = negP ? -{1'b0, quoNx[W-2:0]} : {1'b0, quoNx[W-2:0]};
  assign remSgn = negR ? -remNx : remNx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqA <= '0;
      seqB <= '0;
      seqM <= '0;
      negP <= 1'b0;
      negR <= 1'b0;
    end else if (strb.seqLoadMul) begin
      seqA <= '0;
      seqB <= mqMag;
      seqM <= opMag;
      negP <= mq[W-1] ^ operand[W-1];
    end else if (strb.seqLoadDiv) begin
      seqA <= accMag;
      seqB <= '0;
      seqM <= opMag;
      negP <= signDiff;
      negR <= acc[W-1];
    end else if (strb.seqStepMul) begin
      seqA <= mulHiNx;
      seqB <= mulLoNx;
    end else if (strb.seqStepDiv) begin
      seqA <= remNx;
      seqB <= quoNx;
    end
  end

  logic [W-1:0] accNx, mqNx;

  always_comb begin
    case (strb.accSel)
      ACC_ALU:     accNx = aluSum;
      ACC_FROM_MQ: accNx = mq;
      ACC_DBL:     accNx = {acc[W-2:0], 1'b0};
      ACC_HALF:    accNx = {acc[W-1], acc[W-1:1]};
      ACC_MUL:     accNx = prodSgn[2*W-2:W-1];
      ACC_DIV:     accNx = remSgn;
      ACC_ZERO:    accNx = '0;
      default:     accNx = acc;
    endcase
    case (strb.mqSel)
      MQ_OPND:   mqNx = operand;
      MQ_MUL:    mqNx = {1'b0, prodSgn[W-2:0]};
      MQ_DIV:    mqNx = quoSgn;
      MQ_SAT:    mqNx = signDiff ? MOST_NEG : MOST_POS;
      MQ_NEGONE: mqNx = MOST_NEG;
      default:   mqNx = mq;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      mq     <= '0;
      divErr <= 1'b0;
    end else begin
      acc <= accNx;
      mq  <= mqNx;
      if (strb.setErr) divErr <= 1'b1;
    end
  end

endmodule

// File: rtl/acmq_unit.sv
module acmq_unit
  import acmq_pkg::*;
#(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [3:0]   opCode,
  input  logic [W-1:0] operand,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] acc,
  output logic [W-1:0] mq,
  output logic         accNonNeg,
  output logic         divErr
);
  strobe_t strb;
  logic divFault, divExactNeg;

  acmq_ctrl #(.W(W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .opCode      (opCode),
    .divFault    (divFault),
    .divExactNeg (divExactNeg),
    .strb        (strb),
    .busy        (busy),
    .done        (done)
  );

  acmq_dp #(.W(W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .operand     (operand),
    .acc         (acc),
    .mq          (mq),
    .divErr      (divErr),
    .divFault    (divFault),
    .divExactNeg (divExactNeg)
  );

  assign accNonNeg = ~acc[W-1];

endmodule

// File: rtl/acmq_unit_chk.sv
module acmq_unit_chk #(
  parameter int W = 40
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic [3:0]   opCode,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] acc,
  input logic [W-1:0] mq,
  input logic         divErr
);

  // R12: completion and sequencing never overlap
  p_busy_done_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R12: completion lasts one cycle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: registers frozen while a sequence runs
  p_acc_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> $stable(acc));

  p_mq_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> $stable(mq));

  // R7: error flag is sticky
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    divErr |=> divErr);

  // R9: non-sequenced codes finish after one edge
  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && opCode != 4'd10 && opCode != 4'd11) |=> done);

  // R9: multiply always enters the sequencer
  p_mul_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && opCode == 4'd10) |=> (busy && !done));

endmodule

bind acmq_unit acmq_unit_chk #(.W(W)) i_acmq_unit_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .opCode (opCode),
  .busy   (busy),
  .done   (done),
  .acc    (acc),
  .mq     (mq),
  .divErr (divErr)
);

// File: tb/test_acmq_unit.sv
`timescale 1ns/1ps
module test_acmq_unit;

  localparam int W  = 40;
  localparam int NV = 29;

  logic         clk = 1'b0;
  logic         rstN;
  logic         start;
  logic [3:0]   opCode;
  logic [W-1:0] operand;
  logic         busy, done, accNonNeg, divErr;
  logic [W-1:0] acc, mq;

  int checks   = 0;
  int failures = 0;

  // model state
  logic [W-1:0] mAc, mMq;
  logic         mErr;

  always #4 clk = ~clk;

  acmq_unit #(.W(W)) i_acmq_unit (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .operand(operand),
    .busy(busy), .done(done), .acc(acc), .mq(mq), .accNonNeg(accNonNeg), .divErr(divErr)
  );

  // {code, operand}
  localparam logic [43:0] VEC [NV] = '{
    {4'd0,  40'h4000000000}, {4'd4,  40'h2000000000}, {4'd5,  40'hC000000000},
    {4'd1,  40'h1234567890}, {4'd2,  40'hF000000001}, {4'd3,  40'h0000000123},
    {4'd6,  40'h8000000000}, {4'd7,  40'hFFFFFFFFFF}, {4'd8,  40'h6666666666},
    {4'd0,  40'hA5A5A5A5A5}, {4'd10, 40'h3333333333}, {4'd9,  40'h0000000000},
    {4'd12, 40'h0000000000}, {4'd13, 40'h0000000000}, {4'd1,  40'h7000000000},
    {4'd13, 40'h0000000000}, {4'd8,  40'h8000000000}, {4'd10, 40'h8000000000},
    {4'd0,  40'h2000000000}, {4'd11, 40'h4000000000}, {4'd1,  40'h1000000001},
    {4'd11, 40'h3000000007}, {4'd0,  40'h4000000000}, {4'd11, 40'hC000000000},
    {4'd14, 40'h0000000123}, {4'd0,  40'h8000000000}, {4'd11, 40'h7FFFFFFFFF},
    {4'd11, 40'h0000000000}, {4'd15, 40'h0000000000}
  };

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string tagOf(input logic [3:0] op);
    if (op < 4'd4)        return "R2";
    else if (op < 4'd8)   return "R3";
    else if (op < 4'd10)  return "R4";
    else if (op == 4'd10) return "R5";
    else if (op == 4'd11) return "R6";
    else                  return "R8";
  endfunction

  // reference model, written from the requirements
  task automatic modelApply(input logic [3:0] op, input logic [W-1:0] m, output int lat);
    logic [W-1:0] absM, trm;
    logic signed [79:0] a80, b80, p80, n80, q80, r80;
    logic signed [79:0] qMax, qMin;
    qMax = 80'sh7FFFFFFFFF;
    qMin = -qMax - 80'sd1;
    lat = 1;
    absM = m[W-1] ? -m : m;
    if (op < 4'd8) begin
      trm = op[1] ? absM : m;
      if (op[0]) trm = -trm;
      mAc = (op[2] ? mAc : '0) + trm;
    end else if (op == 4'd8) begin
      mMq = m;
    end else if (op == 4'd9) begin
      mAc = mMq;
    end else if (op == 4'd10) begin
      a80 = {{40{m[W-1]}}, m};
      b80 = {{40{mMq[W-1]}}, mMq};
      p80 = a80 * b80;
      mAc = p80[78:39];
      mMq = {1'b0, p80[38:0]};
      lat = 41;
    end else if (op == 4'd11) begin
      if (m == '0) begin
        mErr = 1'b1;
        mMq  = (mAc[W-1] ^ m[W-1]) ? 40'h8000000000 : 40'h7FFFFFFFFF;
      end else begin
        n80 = {mAc[W-1], mAc, 39'b0};
        b80 = {{40{m[W-1]}}, m};
        q80 = n80 / b80;
        r80 = n80 % b80;
        if (q80 > qMax || q80 < qMin) begin
          mErr = 1'b1;
          mMq  = (mAc[W-1] ^ m[W-1]) ? 40'h8000000000 : 40'h7FFFFFFFFF;
        end else begin
          mMq = q80[39:0];
          mAc = r80[39:0];
          lat = (q80 == qMin) ? 1 : 40;
        end
      end
    end else if (op == 4'd12) begin
      mAc = {mAc[W-2:0], 1'b0};
    end else if (op == 4'd13) begin
      mAc = {mAc[W-1], mAc[W-1:1]};
    end
  endtask

  // issue one command; returns falling edges until done is seen
  task automatic runOp(input logic [3:0] op, input logic [W-1:0] m, output int lat);
    @(negedge clk);
    start = 1'b1; opCode = op; operand = m;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic fullCheck(input logic [3:0] op, input logic [W-1:0] m);
    int lat, expLat;
    string t;
    t = tagOf(op);
    modelApply(op, m, expLat);
    runOp(op, m, lat);
    chk({t, " acc"}, acc, mAc);
    chk({t, " mq"}, mq, mMq);
    chk("R7 divErr", {39'b0, divErr}, {39'b0, mErr});
    chk("R11 accNonNeg", {39'b0, accNonNeg}, {39'b0, ~mAc[W-1]});
    chk("R9 latency", W'(lat), W'(expLat));
    @(negedge clk);
    chk("R12 done drop", {39'b0, done}, 40'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R9 act=timeout exp=completion");
    summary();
    $finish;
  end

  initial begin
    int lat, expLat;
    start = 1'b0; opCode = '0; operand = '0; rstN = 1'b0;
    mAc = '0; mMq = '0; mErr = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 acc", acc, '0);
    chk("R1 mq", mq, '0);
    chk("R1 busy/done/err", {37'b0, busy, done, divErr}, '0);
    chk("R1 accNonNeg", {39'b0, accNonNeg}, 40'd1);

    // R5: 0.5 x 0.5 = 0.25
    fullCheck(4'd8, 40'h4000000000);
    fullCheck(4'd10, 40'h4000000000);
    chk("R5 quarter", acc, 40'h2000000000);
    chk("R5 mq low", mq, 40'h0);
    // R6: 0.25 / 0.5 = 0.5, remainder 0
    fullCheck(4'd11, 40'h4000000000);
    chk("R6 half quotient", mq, 40'h4000000000);
    chk("R6 zero remainder", acc, 40'h0);

    // R10: start during multiply is ignored
    fullCheck(4'd8, 40'h2000000000);
    fullCheck(4'd0, 40'h9876543210);
    modelApply(4'd10, 40'h4000000000, expLat);
    @(negedge clk);
    start = 1'b1; opCode = 4'd10; operand = 40'h4000000000;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; opCode = 4'd8; operand = 40'h7777777777;
    @(negedge clk);
    start = 1'b0;
    lat = 6;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk("R10 latency unchanged", W'(lat), W'(expLat));
    chk("R10 mq is product", mq, mMq);
    chk("R10 acc is product", acc, mAc);
    repeat (3) @(negedge clk);
    chk("R10 no extra done", {39'b0, done}, 40'd0);
    chk("R10 mq untouched", mq, mMq);

    // table walk
    for (int i = 0; i < NV; i++) begin
      fullCheck(VEC[i][43:40], VEC[i][39:0]);
    end
    chk("R7 sticky after faults", {39'b0, divErr}, 40'd1);

    // R1: reset clears the error flag
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 err cleared", {39'b0, divErr}, 40'd0);
    chk("R1 acc cleared", acc, '0);

    summary();
    $finish;
  end

endmodule